// File: doc/BRIEF.md
# Dual-Channel Potentiometer Command Controller

This block is the two-wire serial front end of a two-channel potentiometer register bank. It watches the clock and data lines from a faster system clock, finds START and STOP conditions, shifts in three bytes (a device address, an instruction and a data value) and answers each byte by pulling the data line low in the ninth clock, or by leaving it high. From the decoded instruction it produces a one-cycle write strobe, either for one of four stored data registers or for a wiper register, together with the register index, the wiper index and the data value.

A stored-register write stands in for a slow non-volatile update. It takes effect on the STOP that closes the transaction and then holds the device busy for a set number of system clocks. While busy, the device does not acknowledge its own address, so a host can poll with START and address until it gets an acknowledge. An active-low write-protect input blocks stored-register writes. Instruction and wiper traffic still pass, but a protected data byte is refused. If protection becomes active anywhere between the START and the closing STOP, the pending write is dropped. Protection that becomes active after the busy period has started does not stop that period.

Top module: `dpot_cmd_ctrl`

## Requirements
- R1: An address byte whose upper nibble is 0101 and whose lower nibble equals `dev_addr_i` is acknowledged: the block drives SDA low for the whole ninth clock pulse and releases it after that clock falls. Bytes go MSB first.
- R2: An address byte that differs in either nibble is not acknowledged. Every later byte up to the next START or STOP is also not acknowledged, and no strobe fires.
- R3: In the instruction byte, bits [7:4] are the opcode. 1100 selects a stored-register write and 1010 selects a wiper write, and both are acknowledged. Any other opcode is refused, and the data byte that follows is refused as well.
- R4: In a stored-register write, instruction bits [3:2] give the register index and the data byte is acknowledged. On the STOP that ends the transaction, `dr_wr_o` pulses for exactly one cycle with `reg_idx_o`, `wiper_idx_o` and `wr_data_o` valid.
- R5: In a wiper write, `wcr_wr_o` pulses for one cycle after the data byte, with `wiper_idx_o` and `wr_data_o` valid. No busy period follows, so the next matching address is acknowledged.
- R6: After a stored-register write fires, a matching address is refused for `BUSY_CYCLES` system clocks and is acknowledged again once that time has passed.
- R7: With `wp_n_i` low, the address and instruction bytes are acknowledged, a stored-register data byte is refused, no write happens and no busy period starts. Wiper writes are not affected by `wp_n_i`.
- R8: If `wp_n_i` is low at any time between the START and the closing STOP, the pending stored-register write is dropped, even if `wp_n_i` is high again by the time of the STOP.
- R9: A low `wp_n_i` during an active busy period does not cut it short. Polling is refused until it ends and is acknowledged afterwards.
- R10: A repeated START drops any pending stored-register write and restarts decoding at the address byte.
- R11: Only bit 0 of the instruction byte selects the wiper (0 or 1). Bit 1 is ignored.
- R12: After reset, SDA is released and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as received |
| sda_i | input | 1 | Serial data line as received (wired-AND bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| dev_addr_i | input | 4 | Strapped device address nibble |
| wp_n_i | input | 1 | Write protect, active low |
| dr_wr_o | output | 1 | One-cycle stored-register write strobe |
| wcr_wr_o | output | 1 | One-cycle wiper register write strobe |
| reg_idx_o | output | 2 | Stored-register index |
| wiper_idx_o | output | 1 | Wiper channel index |
| wr_data_o | output | 8 | Data value for the write |

## Verification
The case that is hardest to reach from the ports is a protect pulse that sits wholly inside a transaction after the data byte has been acknowledged. At STOP time `wp_n_i` already looks harmless again, so only the remembered event can cancel the write. The bench drives the data byte with protection off, pulses `wp_n_i` low for a few dozen clocks while SCL is idle and then issues STOP. It then expects no strobe, and expects an immediate acknowledge on a following poll, which shows that no busy period started. The busy window is checked the same way, by counting refused polls before the first acknowledge. This is repeated with protection held low during the wait.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam logic [3:0] DEV_TYPE  = 4'b0101;
    localparam logic [3:0] OP_DREG   = 4'b1100;
    localparam logic [3:0] OP_WIPER  = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INSTR,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_DREG,
        TGT_WIPER
    } target_t;

    typedef struct packed {
        target_t    tgt;
        logic [1:0] reg_idx;
        logic       wiper;
    } cmd_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [3:0] pins);
        return (b[7:4] == DEV_TYPE) && (b[3:0] == pins);
    endfunction

    function automatic cmd_t decode_instr(input logic [7:0] b);
        cmd_t c;
        c.reg_idx = b[3:2];
        c.wiper   = b[0];
        case (b[7:4])
            OP_DREG:  c.tgt = TGT_DREG;
            OP_WIPER: c.tgt = TGT_WIPER;
            default:  c.tgt = TGT_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync
    import dpot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    input  logic     wp_n_i,
    output logic     scl_s,
    output logic     sda_s,
    output logic     wp_s,
    output bus_evt_t evt
);
    localparam int NLINES = 3;

    logic [STAGES-1:0][NLINES-1:0] pipe;
    logic [NLINES-1:0]             raw;
    logic                          scl_p, sda_p;

    assign raw = {wp_n_i, sda_i, scl_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe  <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            pipe  <= {pipe[STAGES-2:0], raw};
            scl_p <= pipe[STAGES-1][0];
            sda_p <= pipe[STAGES-1][1];
        end
    end

    assign scl_s = pipe[STAGES-1][0];
    assign sda_s = pipe[STAGES-1][1];
    assign wp_s  = pipe[STAGES-1][2];

    always_comb begin
        evt.rise  = scl_s & ~scl_p;
        evt.fall  = ~scl_s & scl_p;
        evt.start = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start_i)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - CW'(1);
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/dpot_cmd_fsm.sv
module dpot_cmd_fsm
    import dpot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic       sda_s,
    input  logic       wp_s,
    input  logic       busy,
    input  logic [3:0] dev_addr,
    output logic       sda_oe,
    output logic       dr_wr,
    output logic       wcr_wr,
    output logic [1:0] reg_idx,
    output logic       wiper,
    output logic [7:0] wr_data
);
    phase_t     phase, nxt_phase, dec_next;
    logic [6:0] shreg;
    logic [2:0] bitcnt;
    logic       byte_rdy, in_ack, ack_drv, dec_ack;
    logic       pending, wp_fault, wp_ok;
    cmd_t       cmd, dec_cmd;
    logic [7:0] full_byte;

    assign full_byte = {shreg, sda_s};
    assign wp_ok     = wp_s & ~wp_fault;
    assign dec_cmd   = decode_instr(full_byte);

    always_comb begin
        dec_ack  = 1'b0;
        dec_next = PH_SKIP;
        case (phase)
            PH_ADDR: begin
                if (addr_hit(full_byte, dev_addr) && !busy) begin
                    dec_ack  = 1'b1;
                    dec_next = PH_INSTR;
                end
            end
            PH_INSTR: begin
                if (dec_cmd.tgt != TGT_NONE) begin
                    dec_ack  = 1'b1;
                    dec_next = PH_DATA;
                end
            end
            PH_DATA: begin
                dec_ack = (cmd.tgt == TGT_WIPER) || (cmd.tgt == TGT_DREG && wp_ok);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            nxt_phase <= PH_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            byte_rdy  <= 1'b0;
            in_ack    <= 1'b0;
            ack_drv   <= 1'b0;
            pending   <= 1'b0;
            wp_fault  <= 1'b0;
            cmd       <= '{tgt: TGT_NONE, reg_idx: 2'b00, wiper: 1'b0};
            wr_data   <= '0;
            sda_oe    <= 1'b0;
            dr_wr     <= 1'b0;
            wcr_wr    <= 1'b0;
        end else begin
            dr_wr  <= 1'b0;
            wcr_wr <= 1'b0;
            if (!wp_s)
                wp_fault <= 1'b1;

            if (evt.start) begin
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                byte_rdy <= 1'b0;
                in_ack   <= 1'b0;
                sda_oe   <= 1'b0;
                pending  <= 1'b0;
                wp_fault <= ~wp_s;
            end else if (evt.stop) begin
                if (pending && wp_ok)
                    dr_wr <= 1'b1;
                pending  <= 1'b0;
                phase    <= PH_IDLE;
                byte_rdy <= 1'b0;
                in_ack   <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (evt.rise) begin
                if (!in_ack && (phase == PH_ADDR || phase == PH_INSTR || phase == PH_DATA)) begin
                    shreg  <= full_byte[6:0];
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        byte_rdy  <= 1'b1;
                        ack_drv   <= dec_ack;
                        nxt_phase <= dec_next;
                        if (phase == PH_INSTR && dec_ack)
                            cmd <= dec_cmd;
                        if (phase == PH_DATA && dec_ack) begin
                            wr_data <= full_byte;
                            if (cmd.tgt == TGT_DREG)
                                pending <= 1'b1;
                            else
                                wcr_wr  <= 1'b1;
                        end
                    end
                end
            end else if (evt.fall) begin
                if (byte_rdy) begin
                    byte_rdy <= 1'b0;
                    in_ack   <= 1'b1;
                    sda_oe   <= ack_drv;
                end else if (in_ack) begin
                    in_ack <= 1'b0;
                    sda_oe <= 1'b0;
                    phase  <= nxt_phase;
                    bitcnt <= '0;
                end
            end
        end
    end

    assign reg_idx = cmd.reg_idx;
    assign wiper   = cmd.wiper;

endmodule

// File: rtl/dpot_cmd_ctrl.sv
module dpot_cmd_ctrl
    import dpot_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 50000,
    parameter int unsigned BUSY_CYCLES = CLK_KHZ * 5,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [3:0] dev_addr_i,
    input  logic       wp_n_i,
    output logic       dr_wr_o,
    output logic       wcr_wr_o,
    output logic [1:0] reg_idx_o,
    output logic       wiper_idx_o,
    output logic [7:0] wr_data_o
);
    bus_evt_t evt;
    logic     scl_s, sda_s, wp_s;
    logic     nv_busy;
    logic     stop_det;

    assign stop_det = evt.stop;

    dpot_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .wp_n_i (wp_n_i),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .wp_s   (wp_s),
        .evt    (evt)
    );

    dpot_cmd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sda_s    (sda_s),
        .wp_s     (wp_s),
        .busy     (nv_busy),
        .dev_addr (dev_addr_i),
        .sda_oe   (sda_oe_o),
        .dr_wr    (dr_wr_o),
        .wcr_wr   (wcr_wr_o),
        .reg_idx  (reg_idx_o),
        .wiper    (wiper_idx_o),
        .wr_data  (wr_data_o)
    );

    dpot_nv_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (dr_wr_o),
        .busy_o  (nv_busy)
    );

endmodule

// File: rtl/dpot_cmd_ctrl_chk.sv
module dpot_cmd_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic wp_s,
    input logic stop_evt,
    input logic busy,
    input logic dr_wr,
    input logic wcr_wr,
    input logic sda_oe
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s); // R1

    AST_DREG_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        dr_wr |-> $past(stop_evt)); // R4

    AST_DREG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dr_wr |=> !dr_wr); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dr_wr, wcr_wr})); // R5

    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        dr_wr |=> busy); // R6

    AST_NO_DREG_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dr_wr); // R6

    AST_DREG_UNPROT: assert property (@(posedge clk) disable iff (rst)
        dr_wr |-> $past(wp_s)); // R8

endmodule

bind dpot_cmd_ctrl dpot_cmd_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .wp_s     (wp_s),
    .stop_evt (stop_det),
    .busy     (nv_busy),
    .dr_wr    (dr_wr_o),
    .wcr_wr   (wcr_wr_o),
    .sda_oe   (sda_oe_o)
);

// File: tb/tb_dpot_cmd_ctrl.sv
module tb_dpot_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int BUSY       = 3000;
    localparam logic [3:0] PINS = 4'b1011;
    localparam logic [7:0] ADDR = {4'b0101, PINS};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp_n = 1'b1;
    logic       sda_bus;
    logic       sda_oe, dr_wr, wcr_wr, wiper;
    logic [1:0] reg_idx;
    logic [7:0] wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic       is_dr;
        logic [1:0] ri;
        logic       wp;
        logic [7:0] d;
    } wr_item_t;

    wr_item_t exp_q[$];

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpot_cmd_ctrl #(.BUSY_CYCLES(BUSY)) dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .dev_addr_i  (PINS),
        .wp_n_i      (wp_n),
        .dr_wr_o     (dr_wr),
        .wcr_wr_o    (wcr_wr),
        .reg_idx_o   (reg_idx),
        .wiper_idx_o (wiper),
        .wr_data_o   (wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: every strobe must match the next queued expectation
    always @(negedge clk) begin
        if (!rst && (dr_wr || wcr_wr)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4/R5 unexpected strobe", {dr_wr, wcr_wr}, 0);
            end else begin
                wr_item_t e;
                wr_item_t a;
                e = exp_q.pop_front();
                a = '{is_dr: dr_wr, ri: reg_idx, wp: wiper, d: wdata};
                chk(a == e && (dr_wr ^ wcr_wr), "R4/R5/R11 strobe contents", int'(a), int'(e));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        tick(HALF/2); sda_m = 1'b1;
        tick(HALF/2); scl_m = 1'b1;
        tick(HALF/2); sda_m = 1'b0;
        tick(HALF/2); scl_m = 1'b0;
    endtask

    task automatic do_stop();
        tick(HALF/2); sda_m = 1'b0;
        tick(HALF/2); scl_m = 1'b1;
        tick(HALF/2); sda_m = 1'b1;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            tick(HALF/2); sda_m = b[i];
            tick(HALF/2); scl_m = 1'b1;
            tick(HALF);   scl_m = 1'b0;
        end
        tick(HALF/2); sda_m = 1'b1;
        tick(HALF/2); scl_m = 1'b1;
        tick(HALF/2); acked = ~sda_bus;
        tick(HALF/2); scl_m = 1'b0;
    endtask

    task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        send_byte(b, a);
        chk(a == exp_ack, req, a, exp_ack);
    endtask

    task automatic poll(output bit acked);
        do_start();
        send_byte(ADDR, acked);
        do_stop();
    endtask

    task automatic wait_ready(output int nacks, output bit got);
        bit a;
        nacks = 0;
        got = 0;
        for (int k = 0; k < 30; k++) begin
            poll(a);
            if (a) begin
                got = 1;
                break;
            end
            nacks++;
        end
    endtask

    task automatic queue_empty(input string req);
        tick(8);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        int n;
        bit got;

        tick(5);
        rst = 1'b0;
        tick(3);
        // R12 reset state
        chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
        chk({dr_wr, wcr_wr} == 2'b00, "R12 strobes idle", {dr_wr, wcr_wr}, 0);

        // R5 wiper write to wiper 1
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hA1, 1, "R3 wiper opcode ack");
        exp_q.push_back('{is_dr: 1'b0, ri: 2'b00, wp: 1'b1, d: 8'h3C});
        send_chk(8'h3C, 1, "R5 wiper data ack");
        do_stop();
        queue_empty("R5 wiper strobe seen");
        poll(a);
        chk(a == 1'b1, "R5 no busy after wiper write", a, 1);

        // R4 stored-register write, reg 2, wiper 0
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hC8, 1, "R3 dreg opcode ack");
        send_chk(8'hA5, 1, "R4 dreg data ack");
        chk(exp_q.size() == 0 && !dr_wr, "R4 no strobe before stop", dr_wr, 0);
        exp_q.push_back('{is_dr: 1'b1, ri: 2'b10, wp: 1'b0, d: 8'hA5});
        do_stop();
        queue_empty("R4 dreg strobe at stop");

        // R6 busy polling
        wait_ready(n, got);
        chk(got == 1'b1, "R6 ack after busy", got, 1);
        chk(n >= 2 && n <= 12, "R6 refused polls during busy", n, 5);

        // R2 mismatches
        do_start();
        send_chk(8'h4B, 0, "R2 type mismatch nack");
        send_chk(8'hA1, 0, "R2 later byte nack");
        send_chk(8'h11, 0, "R2 later byte nack");
        do_stop();
        do_start();
        send_chk(8'h5A, 0, "R2 pin mismatch nack");
        send_chk(8'hC0, 0, "R2 later byte nack");
        do_stop();
        queue_empty("R2 no strobe");

        // R3 bad opcode
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hF0, 0, "R3 bad opcode nack");
        send_chk(8'h55, 0, "R3 data after bad opcode nack");
        do_stop();
        queue_empty("R3 no strobe");

        // R11 wiper field upper bit ignored
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hA6, 1, "R11 wiper opcode ack");
        exp_q.push_back('{is_dr: 1'b0, ri: 2'b01, wp: 1'b0, d: 8'h81});
        send_chk(8'h81, 1, "R11 data ack");
        do_stop();
        queue_empty("R11 wiper field 10 selects wiper 0");
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hCF, 1, "R11 dreg opcode ack");
        send_chk(8'h77, 1, "R11 data ack");
        exp_q.push_back('{is_dr: 1'b1, ri: 2'b11, wp: 1'b1, d: 8'h77});
        do_stop();
        queue_empty("R11 wiper field 11 selects wiper 1");
        wait_ready(n, got);
        chk(got == 1'b1, "R6 ack after busy", got, 1);

        // R7 write protect held low
        wp_n = 1'b0;
        do_start();
        send_chk(ADDR, 1, "R7 address ack under protect");
        send_chk(8'hC4, 1, "R7 instruction ack under protect");
        send_chk(8'h99, 0, "R7 data nack under protect");
        do_stop();
        queue_empty("R7 no dreg write");
        poll(a);
        chk(a == 1'b1, "R7 no busy after refused write", a, 1);
        do_start();
        send_chk(ADDR, 1, "R7 address ack");
        send_chk(8'hA0, 1, "R7 wiper opcode ack");
        exp_q.push_back('{is_dr: 1'b0, ri: 2'b00, wp: 1'b0, d: 8'h42});
        send_chk(8'h42, 1, "R7 wiper data ack under protect");
        do_stop();
        queue_empty("R7 wiper write unaffected");
        wp_n = 1'b1;
        tick(10);

        // R8 protect pulse between data ack and stop
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hC4, 1, "R3 dreg opcode ack");
        send_chk(8'h5E, 1, "R8 data ack while unprotected");
        tick(HALF);
        wp_n = 1'b0;
        tick(50);
        wp_n = 1'b1;
        tick(20);
        do_stop();
        queue_empty("R8 pending write dropped");
        poll(a);
        chk(a == 1'b1, "R8 no busy after dropped write", a, 1);

        // R10 repeated start drops pending write
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hC0, 1, "R3 dreg opcode ack");
        send_chk(8'hE7, 1, "R10 data ack");
        do_start();
        send_chk(ADDR, 1, "R10 address after repeated start");
        send_chk(8'hA1, 1, "R10 wiper opcode ack");
        exp_q.push_back('{is_dr: 1'b0, ri: 2'b00, wp: 1'b1, d: 8'h12});
        send_chk(8'h12, 1, "R10 wiper data ack");
        do_stop();
        queue_empty("R10 only wiper strobe");
        poll(a);
        chk(a == 1'b1, "R10 no busy", a, 1);

        // R9 protect goes low during busy
        do_start();
        send_chk(ADDR, 1, "R1 address ack");
        send_chk(8'hC4, 1, "R3 dreg opcode ack");
        send_chk(8'h3A, 1, "R9 data ack");
        exp_q.push_back('{is_dr: 1'b1, ri: 2'b01, wp: 1'b0, d: 8'h3A});
        do_stop();
        queue_empty("R9 write fired");
        wp_n = 1'b0;
        wait_ready(n, got);
        chk(got == 1'b1, "R9 busy ends with protect low", got, 1);
        chk(n >= 2 && n <= 12, "R9 busy runs full length", n, 5);
        wp_n = 1'b1;

        tick(20);
        chk(exp_q.size() == 0, "R4/R5 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule